// File: doc/BRIEF.md
# Saturating Cache Hit and Miss Monitors

This block keeps two profiling counters next to a cache lookup pipeline. Each cycle it receives one lookup outcome: whether a request is present, whether that request is cacheable, whether the tag array matched, and whether the address falls inside the line refill that is still in progress. It sorts the outcome into a hit or a miss and counts each class in its own counter.

Software drives the enable and clear level of each counter from its control register and reads the values back. Both counters stop at their all-ones value and never wrap. A clear level that stays high keeps its counter at zero until the level drops. Neither counter changes on noncacheable or bypassed traffic.

Top module: `cache_perf_monitor`

## Requirements
- R1: With default parameters the hit count output is 32 bits wide and the miss count output is 16 bits wide.
- R2: When a request is valid, cacheable and matches the tag array, and the hit enable is 1, the hit count rises by one on the next clock edge.
- R3: A valid cacheable request that matches only the in-flight refill also counts as a hit. A request that matches both the tag array and the refill counts as one hit.
- R4: A valid cacheable request that matches neither the tag array nor the refill raises the miss count by one on the next edge when the miss enable is 1.
- R5: A cycle with no valid request, or with a noncacheable request, changes neither count, whatever the match inputs show.
- R6: A counter at its all-ones value keeps that value on further events and never wraps to zero.
- R7: While its enable is 0 a counter keeps its current value. Counting resumes from that value when the enable returns to 1.
- R8: While its clear input is 1 a counter reads zero on every following cycle and does not count. Counting restarts from zero after the clear input returns to 0.
- R9: If a counter's clear is 1 in the same cycle as one of its enabled events, the counter goes to zero.
- R10: Asynchronous reset (rst_ni low) forces both counts to zero.
- R11: The enable and clear inputs of one counter have no effect on the other counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | A lookup outcome is present this cycle |
| req_cacheable_i | input | 1 | The lookup is cacheable (1) or bypassed (0) |
| tag_hit_i | input | 1 | The address matched a valid tag entry |
| refill_hit_i | input | 1 | The address lies in the line being refilled |
| hit_en_i | input | 1 | Hit counter enable level |
| hit_clr_i | input | 1 | Hit counter clear level |
| miss_en_i | input | 1 | Miss counter enable level |
| miss_clr_i | input | 1 | Miss counter clear level |
| hit_count_o | output | HIT_W | Hit counter value |
| miss_count_o | output | MISS_W | Miss counter value |

## Verification
The assertions assume that each lookup outcome lasts exactly one cycle and that the lookup inputs are known whenever reset is released. They also assume that the enable and clear levels change only between clock edges. The bench drives every input on the falling edge and keeps one outcome per cycle. It sweeps all sixteen combinations of the four lookup inputs under each enable and clear setting. It also uses narrow counter widths so that saturation is reached after a few cycles and sits inside the sweep.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
  typedef struct packed {
    logic hit;
    logic miss;
  } cpm_evt_t;
endpackage

// File: rtl/cpm_event_sort.sv
module cpm_event_sort
  import cpm_pkg::*;
(
  input  logic     req_valid_i,
  input  logic     req_cacheable_i,
  input  logic     tag_hit_i,
  input  logic     refill_hit_i,
  output cpm_evt_t evt_o
);
  logic lookup;

  // bypassed traffic never reaches either counter
  assign lookup     = req_valid_i & req_cacheable_i;
  assign evt_o.hit  = lookup & (tag_hit_i | refill_hit_i);
  assign evt_o.miss = lookup & ~tag_hit_i & ~refill_hit_i;
endmodule

// File: rtl/cpm_sat_counter.sv
module cpm_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         evt_i,
  input  logic         en_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic         at_max;

  assign at_max = (cnt_q == CNT_MAX);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i)                   cnt_q <= '0;
    else if (en_i && evt_i && !at_max) cnt_q <= cnt_q + W'(1);
  end

  a_r8_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));
  a_r6_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == CNT_MAX && !clr_i) |=> (cnt_o == CNT_MAX));
  a_r7_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(cnt_o));
  a_r2_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && $past(!clr_i)) |-> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + W'(1)));
endmodule

// File: rtl/cache_perf_monitor.sv
module cache_perf_monitor
  import cpm_pkg::*;
#(
  parameter int HIT_W  = 32,
  parameter int MISS_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_cacheable_i,
  input  logic              tag_hit_i,
  input  logic              refill_hit_i,
  input  logic              hit_en_i,
  input  logic              hit_clr_i,
  input  logic              miss_en_i,
  input  logic              miss_clr_i,
  output logic [HIT_W-1:0]  hit_count_o,
  output logic [MISS_W-1:0] miss_count_o
);
  cpm_evt_t evt;

  cpm_event_sort u_sort (
    .req_valid_i     (req_valid_i),
    .req_cacheable_i (req_cacheable_i),
    .tag_hit_i       (tag_hit_i),
    .refill_hit_i    (refill_hit_i),
    .evt_o           (evt)
  );

  cpm_sat_counter #(.W(HIT_W)) u_hit_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt.hit),
    .en_i   (hit_en_i),
    .clr_i  (hit_clr_i),
    .cnt_o  (hit_count_o)
  );

  cpm_sat_counter #(.W(MISS_W)) u_miss_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt.miss),
    .en_i   (miss_en_i),
    .clr_i  (miss_clr_i),
    .cnt_o  (miss_count_o)
  );

  a_r3_hit_miss_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(evt.hit && evt.miss));
  a_r5_bypass_no_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(req_valid_i && req_cacheable_i) && !hit_clr_i && !miss_clr_i)
      |=> ($stable(hit_count_o) && $stable(miss_count_o)));
  a_r11_miss_idle_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_cacheable_i && tag_hit_i && !miss_clr_i) |=> $stable(miss_count_o));
endmodule

// File: tb/sim_cache_perf_monitor.sv
`timescale 1ns/1ps
module sim_cache_perf_monitor;
  localparam int HW = 4;
  localparam int MW = 3;
  localparam int HMAX = (1 << HW) - 1;
  localparam int MMAX = (1 << MW) - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic v = 0, c = 0, t = 0, r = 0;
  logic hen = 0, hclr = 0, men = 0, mclr = 0;
  logic [HW-1:0] hit_cnt;
  logic [MW-1:0] miss_cnt;
  logic [31:0] d_hit;
  logic [15:0] d_miss;

  int total = 0, bad = 0;
  int exp_h = 0, exp_m = 0;

  always #2.5 clk = ~clk;

  cache_perf_monitor #(.HIT_W(HW), .MISS_W(MW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(v), .req_cacheable_i(c),
    .tag_hit_i(t), .refill_hit_i(r), .hit_en_i(hen), .hit_clr_i(hclr),
    .miss_en_i(men), .miss_clr_i(mclr), .hit_count_o(hit_cnt), .miss_count_o(miss_cnt)
  );

  cache_perf_monitor u_dflt (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(v), .req_cacheable_i(c),
    .tag_hit_i(t), .refill_hit_i(r), .hit_en_i(hen), .hit_clr_i(hclr),
    .miss_en_i(men), .miss_clr_i(mclr), .hit_count_o(d_hit), .miss_count_o(d_miss)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // one cycle: drive at falling edge, model the rising edge, sample after it
  task automatic step(string req, logic iv, logic ic, logic it, logic ir,
                      logic ihe, logic ihc, logic ime, logic imc);
    bit he, me;
    @(negedge clk);
    v = iv; c = ic; t = it; r = ir; hen = ihe; hclr = ihc; men = ime; mclr = imc;
    he = iv && ic && (it || ir);
    me = iv && ic && !it && !ir;
    @(posedge clk);
    if (ihc) exp_h = 0;
    else if (ihe && he && exp_h < HMAX) exp_h++;
    if (imc) exp_m = 0;
    else if (ime && me && exp_m < MMAX) exp_m++;
    #1;
    check({req, " hit"}, int'(hit_cnt), exp_h);
    check({req, " miss"}, int'(miss_cnt), exp_m);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    #7;
    // R10: counts zero while in reset
    check("R10 reset hit", int'(hit_cnt), 0);
    check("R10 reset miss", int'(miss_cnt), 0);
    check("R10 reset wide hit", int'(d_hit), 0);
    // R1: default widths
    check("R1 hit width", $bits(d_hit), 32);
    check("R1 miss width", $bits(d_miss), 16);
    check("R1 dflt hit port", $bits(u_dflt.hit_count_o), 32);
    check("R1 dflt miss port", $bits(u_dflt.miss_count_o), 16);
    @(negedge clk); rst_ni = 1'b1;

    // R2 tag hit, R3 refill hit and both, R4 miss
    step("R2 tag hit", 1, 1, 1, 0, 1, 0, 1, 0);
    step("R3 refill hit", 1, 1, 0, 1, 1, 0, 1, 0);
    step("R3 both match", 1, 1, 1, 1, 1, 0, 1, 0);
    step("R4 miss", 1, 1, 0, 0, 1, 0, 1, 0);
    // R5 bypass and idle
    step("R5 noncacheable", 1, 0, 1, 0, 1, 0, 1, 0);
    step("R5 noncacheable miss", 1, 0, 0, 0, 1, 0, 1, 0);
    step("R5 idle", 0, 1, 0, 0, 1, 0, 1, 0);

    // exhaustive lookup sweep for every enable/clear setting; saturates (R6)
    for (int ctl = 0; ctl < 16; ctl++)
      for (int rep = 0; rep < 3; rep++)
        for (int p = 0; p < 16; p++)
          step("R6 sweep", p[3], p[2], p[1], p[0], ctl[0], ctl[1], ctl[2], ctl[3]);

    // R6: drive both to saturation then keep pushing
    for (int i = 0; i < HMAX + 4; i++) step("R6 hit sat", 1, 1, 1, 0, 1, 0, 1, 0);
    for (int i = 0; i < MMAX + 4; i++) step("R6 miss sat", 1, 1, 0, 0, 1, 0, 1, 0);
    check("R6 hit at max", int'(hit_cnt), HMAX);
    check("R6 miss at max", int'(miss_cnt), MMAX);

    // R8: held clear blocks counting, then resumes from zero
    for (int i = 0; i < 4; i++) step("R8 hit clr held", 1, 1, 1, 0, 1, 1, 1, 0);
    check("R8 hit zero", int'(hit_cnt), 0);
    step("R8 hit resume", 1, 1, 1, 0, 1, 0, 1, 0);
    check("R8 hit one", int'(hit_cnt), 1);
    // R9: clear and event together
    step("R9 miss clr vs evt", 1, 1, 0, 0, 1, 0, 1, 1);
    check("R9 miss zero", int'(miss_cnt), 0);

    // R7: enable off keeps value, resume continues
    step("R7 prep", 1, 1, 0, 0, 1, 0, 1, 0);
    for (int i = 0; i < 3; i++) step("R7 hit off", 1, 1, 1, 0, 0, 0, 1, 0);
    for (int i = 0; i < 3; i++) step("R7 miss off", 1, 1, 0, 0, 1, 0, 0, 0);
    check("R7 hit held", int'(hit_cnt), 1);
    check("R7 miss held", int'(miss_cnt), 1);
    step("R7 hit resume", 1, 1, 0, 1, 1, 0, 1, 0);
    check("R7 hit two", int'(hit_cnt), 2);

    // R11: one counter's controls leave the other alone
    step("R11 hit clr only", 1, 1, 0, 0, 1, 1, 1, 0);
    check("R11 miss kept", int'(miss_cnt), 2);
    step("R11 miss clr only", 1, 1, 1, 0, 1, 0, 1, 1);
    check("R11 hit kept", int'(hit_cnt), 1);

    // R10: asynchronous reset mid-run
    step("R10 prep", 1, 1, 0, 0, 1, 0, 1, 0);
    #1 rst_ni = 1'b0; #1;
    exp_h = 0; exp_m = 0;
    check("R10 async hit", int'(hit_cnt), 0);
    check("R10 async miss", int'(miss_cnt), 0);
    finish_run();
  end
endmodule